// File: doc/BRIEF.md
# TLB Virtual Page Tag Register

This block is the 64-bit register that holds the virtual page tag used when a TLB-based memory management unit matches, reads or writes a translation entry. It holds four live fields: a two-bit address region, the virtual page number divided by two, a two-bit extension for 1KB pages and an 8-bit address space identifier. The bits between the region and the top implemented page-number bit, and bits 10..8, are not stored and always read as zero.

Three sources can update the register. A TLB exception strobe captures the faulting virtual address and leaves the address space identifier alone. A TLB read strobe loads every field from a selected entry. A software write port loads every field from a data word. When more than one strobe is active in a cycle, the exception capture wins, then the TLB read, then the software write.

The 1KB-page extension field exists only while two configuration inputs are both high. A compatibility input limits the region field to the values 00 and 11. Because the unimplemented bits read back as zero, software can write all ones and read the result to learn how wide the virtual address is. A one-cycle pulse tells the fault-address and context registers that a hardware capture took place. A software write never raises this pulse.

Top module: `tlb_vtag_reg`

## Requirements
- R1: After reset, rd_data is all zeros and vaddr_capture is 0.
- R2: With only sw_we high, the next cycle's rd_data shows the region (63..62), page number (VA_TOP..13), extension (12..11, only while it is enabled) and address space ID (7..0) taken from sw_wdata.
- R3: Bits 61..VA_TOP+1 and 10..8 of rd_data are always zero, and writes to them are ignored. With VA_TOP=39 and the extension enabled, writing all ones reads back 0xC00000FF_FFFFF8FF.
- R4: With exc_capture high, the next cycle's rd_data holds exc_vaddr[63:62] in the region field and exc_vaddr[VA_TOP:13] in the page number field. The address space ID is unchanged.
- R5: The extension field is enabled only while cfg_small_page and cfg_grain_en are both 1. While it is enabled, an exception captures exc_vaddr[12:11] into it. While it is disabled, it is cleared at the next clock edge, reads as zero and ignores every source.
- R6: With tlbr_load high and exc_capture low, the next cycle's rd_data holds every field of tlbr_entry, including the address space ID.
- R7: When the strobes overlap, exc_capture takes priority over tlbr_load, and tlbr_load takes priority over sw_we.
- R8: While cfg_compat32 is 1, every update writes the region field as two copies of the source's bit 63, so that the field only ever holds 00 or 11.
- R9: vaddr_capture is 1 in exactly the cycle after a cycle with exc_capture high. Software writes and TLB reads never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| exc_capture | input | 1 | TLB exception capture strobe |
| exc_vaddr | input | 64 | Faulting virtual address |
| tlbr_load | input | 1 | TLB read load strobe |
| tlbr_entry | input | 64 | Tag image of the selected TLB entry |
| cfg_small_page | input | 1 | Small-page support configuration bit |
| cfg_grain_en | input | 1 | Page-grain enable for 1KB pages |
| cfg_compat32 | input | 1 | 32-bit compatibility-only mode |
| rd_data | output | 64 | Masked register image |
| vaddr_capture | output | 1 | Pulse asking the fault-address and context registers to update |

## Verification
Directed steps write all ones with the extension enabled and then disabled, which separates stored fields from fill and reserved bits. They also raise all three strobes at once and then strobe pairs, which separates the three priority levels by whether the address space ID survives. A compatibility-mode capture with exc_vaddr[63:62]=10 separates a region that is passed through from one that is coerced. Random cycles mix strobe combinations, data and configuration bits, and each result is compared against a bench model of the field rules.

// File: rtl/tlb_vtag_reg.sv
module tlb_vtag_reg #(
  parameter int VA_TOP = 39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_we,
  input  logic [63:0] sw_wdata,
  input  logic        exc_capture,
  input  logic [63:0] exc_vaddr,
  input  logic        tlbr_load,
  input  logic [63:0] tlbr_entry,
  input  logic        cfg_small_page,
  input  logic        cfg_grain_en,
  input  logic        cfg_compat32,
  output logic [63:0] rd_data,
  output logic        vaddr_capture
);
  localparam int FILL_W = 61 - VA_TOP;
  localparam int VPN_W  = VA_TOP - 12;

  logic [1:0]       region, region_n;
  logic [VPN_W-1:0] vpn, vpn_n;
  logic [1:0]       ext, ext_n;
  logic [7:0]       asid, asid_n;
  logic             ext_en;
  logic [63:0]      src;

  assign ext_en = cfg_small_page & cfg_grain_en;
  assign src    = tlbr_load ? tlbr_entry : sw_wdata;

  function automatic logic [1:0] legal_region(input logic [1:0] r, input logic compat);
    return compat ? {r[1], r[1]} : r;
  endfunction

  always_comb begin
    region_n = region;
    vpn_n    = vpn;
    ext_n    = ext_en ? ext : 2'b00;
    asid_n   = asid;
    if (exc_capture) begin
      region_n = legal_region(exc_vaddr[63:62], cfg_compat32);
      vpn_n    = exc_vaddr[VA_TOP:13];
      ext_n    = ext_en ? exc_vaddr[12:11] : 2'b00;
    end else if (tlbr_load || sw_we) begin
      region_n = legal_region(src[63:62], cfg_compat32);
      vpn_n    = src[VA_TOP:13];
      ext_n    = ext_en ? src[12:11] : 2'b00;
      asid_n   = src[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region        <= '0;
      vpn           <= '0;
      ext           <= '0;
      asid          <= '0;
      vaddr_capture <= 1'b0;
    end else begin
      region        <= region_n;
      vpn           <= vpn_n;
      ext           <= ext_n;
      asid          <= asid_n;
      vaddr_capture <= exc_capture;
    end
  end

  assign rd_data = {region, {FILL_W{1'b0}}, vpn, ext & {2{ext_en}}, 3'b000, asid};

  p_exc_vpn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_capture |=> rd_data[VA_TOP:13] == $past(exc_vaddr[VA_TOP:13]));
  p_exc_asid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_capture |=> rd_data[7:0] == $past(rd_data[7:0]));
  p_ext_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> ext == 2'b00);
  p_tlbr_asid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbr_load && !exc_capture) |=> rd_data[7:0] == $past(tlbr_entry[7:0]));
  p_tlbr_over_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbr_load && sw_we && !exc_capture) |=> rd_data[VA_TOP:13] == $past(tlbr_entry[VA_TOP:13]));
  p_compat_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_compat32 && (exc_capture || tlbr_load || sw_we)) |=> rd_data[63] == rd_data[62]);
  p_vcap_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vaddr_capture |-> $past(exc_capture));
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10:8] == 3'b000);
endmodule

// File: tb/tb_tlb_vtag_reg.sv
`timescale 1ns/1ps
module tb_tlb_vtag_reg;
  localparam int VA_TOP = 39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0, exc_capture = 1'b0, tlbr_load = 1'b0;
  logic [63:0] sw_wdata = '0, exc_vaddr = '0, tlbr_entry = '0;
  logic        cfg_small_page = 1'b0, cfg_grain_en = 1'b0, cfg_compat32 = 1'b0;
  logic [63:0] rd_data;
  logic        vaddr_capture;

  int tests = 0, fails = 0;
  logic [63:0] m = '0;
  bit done = 1'b0;

  tlb_vtag_reg #(.VA_TOP(VA_TOP)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [63:0] field_mask(input logic en);
    logic [63:0] k = '0;
    k[63:62] = 2'b11;
    for (int i = 13; i <= VA_TOP; i++) k[i] = 1'b1;
    k[12:11] = en ? 2'b11 : 2'b00;
    k[7:0] = 8'hFF;
    return k;
  endfunction

  function automatic logic [63:0] model_next(input logic [63:0] cur);
    logic en = cfg_small_page & cfg_grain_en;
    logic [63:0] n = cur;
    logic [63:0] s;
    if (!en) n[12:11] = 2'b00;
    if (exc_capture) begin
      s = exc_vaddr & field_mask(en);
      n = (cur & 64'hFF) | (s & ~64'hFF);
    end else if (tlbr_load) n = tlbr_entry & field_mask(en);
    else if (sw_we) n = sw_wdata & field_mask(en);
    if (cfg_compat32 && (exc_capture || tlbr_load || sw_we)) n[62] = n[63];
    return n;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic [63:0] nx = model_next(m);
    logic exp_cap = exc_capture;
    @(posedge clk);
    @(negedge clk);
    m = nx;
    check(tag, rd_data, m & field_mask(cfg_small_page & cfg_grain_en));
    check("R9", {63'b0, vaddr_capture}, {63'b0, exp_cap});
    sw_we = 1'b0; exc_capture = 1'b0; tlbr_load = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", rd_data, 64'h0);
    check("R1", {63'b0, vaddr_capture}, 64'h0);

    cfg_small_page = 1'b1; cfg_grain_en = 1'b1;
    sw_we = 1'b1; sw_wdata = '1;
    cycle("R3");
    check("R3", rd_data, 64'hC00000FF_FFFFF8FF);
    cfg_grain_en = 1'b0;
    cycle("R5");
    check("R5", rd_data, 64'hC00000FF_FFFFE0FF);

    cfg_grain_en = 1'b1;
    sw_we = 1'b1; sw_wdata = 64'h4000_0012_3456_7A5C;
    cycle("R2");
    exc_capture = 1'b1; tlbr_load = 1'b1; sw_we = 1'b1;
    exc_vaddr = 64'h8000_00AB_CDEF_1800; tlbr_entry = 64'hFFFF_FFFF_FFFF_FF11; sw_wdata = 64'h22;
    cycle("R7");
    check("R7", {56'b0, rd_data[7:0]}, 64'h5C);
    check("R4", {54'b0, rd_data[12:11], rd_data[63:56]}, {54'b0, 2'b11, 8'h80});
    tlbr_load = 1'b1; sw_we = 1'b1; tlbr_entry = 64'h0000_0011_1111_1133; sw_wdata = 64'h44;
    cycle("R7");
    check("R6", {56'b0, rd_data[7:0]}, 64'h33);

    cfg_compat32 = 1'b1; exc_capture = 1'b1; exc_vaddr = 64'h8000_0000_0000_0000;
    cycle("R8");
    check("R8", {62'b0, rd_data[63:62]}, 64'h3);
    cfg_compat32 = 1'b0; exc_capture = 1'b1; exc_vaddr = 64'h8000_0000_0000_0000;
    cycle("R4");
    check("R4", {62'b0, rd_data[63:62]}, 64'h2);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sel = 3'($urandom);
      exc_capture = sel[0] & ($urandom % 3 == 0);
      tlbr_load = sel[1];
      sw_we = sel[2];
      exc_vaddr = {$urandom, $urandom};
      tlbr_entry = {$urandom, $urandom};
      sw_wdata = {$urandom, $urandom};
      if ($urandom % 8 == 0) begin
        cfg_small_page = 1'($urandom);
        cfg_grain_en = 1'($urandom);
        cfg_compat32 = 1'($urandom);
      end
      tag = exc_capture ? "R4" : tlbr_load ? "R6" : sw_we ? "R2" : "R5";
      cycle(tag);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule